// File: doc/BRIEF.md
# Conversion Result FIFO with Watermark Alert

This block sits between a converter that produces one result word per conversion and a host that collects the results in bursts. Results are written into an on-chip circular store as they arrive. A host read port, driven in practice by a serial slave interface, pops the oldest result. A programmable watermark lets the host sleep until a chosen number of results has been collected. When the fill count reaches that level, an interrupt is raised. The interrupt stays high until the host has drained the store completely.

Results keep arriving while the host reads. If the store is full when a result arrives, that result is dropped and a sticky overflow flag records the loss. The host clears the flag by writing one to a clear strobe. A synchronous flush empties the store and drops the interrupt. The overflow record is kept through a flush.

Three small state machines hold the control state. The occupancy machine has the states EMPTY, PARTIAL and FULL. Pushes and pops move it from EMPTY to PARTIAL, from PARTIAL to FULL, from FULL to PARTIAL and from PARTIAL to EMPTY, and a flush returns it to EMPTY. The alert machine has the states COLLECT and ALERT. It moves from COLLECT to ALERT when the count reaches the watermark, and from ALERT to COLLECT when the count is zero or on a flush. The overflow machine has the states CLEAN and LOST. It moves from CLEAN to LOST on a dropped result, and from LOST to CLEAN on a clear strobe when nothing is dropped in the same cycle.

Top module: `conv_fifo_wm`

## Requirements
- R1: After reset, fill_count is 0, empty is 1, full is 0, irq is 0, overflow is 0 and rd_data is 0.
- R2: Accepted results come out in arrival order. rd_data takes the popped word on the clock edge at which rd_en is sampled high and holds it until the next read.
- R3: fill_count equals the number of stored results after each edge. empty is 1 exactly when the count is 0, and full is 1 exactly when the count equals DEPTH.
- R4: In COLLECT, when the registered fill_count is at least the effective watermark, irq goes high at the next edge. A wm_level of 0 acts as 1, and any value above DEPTH acts as DEPTH.
- R5: Once high, irq stays high while fill_count is non-zero, even after the count falls below the watermark. irq falls at the edge after the count has become 0.
- R6: A result presented with cv_valid while full is 1 is not stored, and overflow is set at that edge. A pop in the same cycle still takes place.
- R7: overflow stays set until ovf_clr is high at an edge (write-one-to-clear). A drop in the same cycle wins over the clear.
- R8: A read while the store is empty loads 0 into rd_data and leaves the count and the read order unchanged.
- R9: A push and a pop in the same cycle while the store is neither empty nor full leave fill_count unchanged.
- R10: flush empties the store and clears irq at the next edge, and overrides any push or pop in that cycle. It leaves overflow as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous empty-and-rearm |
| cv_valid | input | 1 | A conversion result is presented |
| cv_data | input | DATA_W | Conversion word |
| rd_en | input | 1 | Host pop request |
| rd_data | output | DATA_W | Last popped word (0 after an empty read) |
| wm_level | input | CNT_W | Watermark, 1 to DEPTH |
| ovf_clr | input | 1 | Write-one-to-clear for overflow |
| fill_count | output | CNT_W | Number of stored results |
| empty | output | 1 | Store is empty |
| full | output | 1 | Store is full |
| irq | output | 1 | Watermark interrupt |
| overflow | output | 1 | Sticky flag: a result was dropped |

## Verification
The bench runs a small store of eight entries. It sweeps every watermark code the port can carry, including 0 and the codes above the depth, through one fill, overfill and drain pattern. For each code, the edge at which irq rises shows the comparison and the clamping. The point at which irq falls shows that the clear waits for a full drain rather than the count dropping below the level. Directed patterns then apply simultaneous push and pop in the empty, partial and full cases, which separates the count-hold rule from the drop and empty-read rules. Further patterns cover a drop in the same cycle as a clear, and a flush while irq and overflow are both high.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

    typedef enum logic [0:0] {
        ST_COLLECT = 1'b0,
        ST_ALERT   = 1'b1
    } alert_state_t;

    typedef enum logic [0:0] {
        OV_CLEAN = 1'b0,
        OV_LOST  = 1'b1
    } ovf_state_t;

endpackage

// File: rtl/wmf_occupancy.sv
module wmf_occupancy #(
    parameter int DEPTH = 256,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    import wmf_pkg::*;

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    occ_state_t       state_q, state_d;
    logic [CNT_W-1:0] count_d;

    // Acceptance decisions use the state held at the start of the cycle.
    assign push_ok = push_req && !flush && (state_q != OCC_FULL);
    assign pop_ok  = pop_req  && !flush && (state_q != OCC_EMPTY);

    always_comb begin
        count_d = count;
        if (flush) begin
            count_d = '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   count_d = count + CNT_W'(1);
                2'b01:   count_d = count - CNT_W'(1);
                default: count_d = count;
            endcase
        end
    end

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = OCC_EMPTY;
        end else begin
            unique case (state_q)
                OCC_EMPTY:   if (push_ok) state_d = (count_d == FULL_CNT) ? OCC_FULL : OCC_PARTIAL;
                OCC_PARTIAL: begin
                    if (count_d == '0)           state_d = OCC_EMPTY;
                    else if (count_d == FULL_CNT) state_d = OCC_FULL;
                end
                OCC_FULL:    if (pop_ok) state_d = (count_d == '0) ? OCC_EMPTY : OCC_PARTIAL;
                default:     state_d = OCC_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            count   <= '0;
        end else begin
            state_q <= state_d;
            count   <= count_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + PTR_W'(1);
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + PTR_W'(1);
        end
    end

    always_comb begin
        empty = 1'b0;
        full  = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   empty = 1'b1;
            OCC_PARTIAL: ;
            OCC_FULL:    full = 1'b1;
            default:     empty = 1'b1;
        endcase
    end

endmodule

// File: rtl/wmf_store.sv
module wmf_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_req,
    input  logic              rd_hit,
    input  logic [PTR_W-1:0]  raddr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // A read of an empty store yields zero; a flush cycle leaves the word alone.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_req && !flush) begin
            rd_data <= rd_hit ? mem[raddr] : '0;
        end
    end

endmodule

// File: rtl/wmf_alert.sv
module wmf_alert #(
    parameter int DEPTH = 256,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] wm_level,
    output logic             irq
);
    import wmf_pkg::*;

    localparam logic [CNT_W-1:0] MAX_WM = CNT_W'(DEPTH);

    alert_state_t     state_q, state_d;
    logic [CNT_W-1:0] wm_eff;

    always_comb begin
        if (wm_level == '0)         wm_eff = CNT_W'(1);
        else if (wm_level > MAX_WM) wm_eff = MAX_WM;
        else                        wm_eff = wm_level;
    end

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = ST_COLLECT;
        end else begin
            unique case (state_q)
                ST_COLLECT: if (count >= wm_eff) state_d = ST_ALERT;
                ST_ALERT:   if (count == '0)     state_d = ST_COLLECT;
                default:    state_d = ST_COLLECT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_COLLECT: irq = 1'b0;
            ST_ALERT:   irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/wmf_overflow.sv
module wmf_overflow (
    input  logic clk,
    input  logic rst_n,
    input  logic drop,
    input  logic clr,
    output logic overflow
);
    import wmf_pkg::*;

    ovf_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OV_CLEAN: if (drop)         state_d = OV_LOST;
            OV_LOST:  if (clr && !drop) state_d = OV_CLEAN;
            default:  state_d = OV_CLEAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OV_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            OV_CLEAN: overflow = 1'b0;
            OV_LOST:  overflow = 1'b1;
            default:  overflow = 1'b0;
        endcase
    end

endmodule

// File: rtl/conv_fifo_wm.sv
module conv_fifo_wm #(
    parameter  int DATA_W = 16,
    parameter  int DEPTH  = 256,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              cv_valid,
    input  logic [DATA_W-1:0] cv_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  wm_level,
    input  logic              ovf_clr,
    output logic [CNT_W-1:0]  fill_count,
    output logic              empty,
    output logic              full,
    output logic              irq,
    output logic              overflow
);
    localparam int PTR_W = $clog2(DEPTH);

    logic             push_ok, pop_ok;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             drop;

    wmf_occupancy #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push_req (cv_valid),
        .pop_req  (rd_en),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (fill_count),
        .empty    (empty),
        .full     (full)
    );

    wmf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .we      (push_ok),
        .waddr   (wr_ptr),
        .wdata   (cv_data),
        .rd_req  (rd_en),
        .rd_hit  (pop_ok),
        .raddr   (rd_ptr),
        .rd_data (rd_data)
    );

    wmf_alert #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_alert (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .count    (fill_count),
        .wm_level (wm_level),
        .irq      (irq)
    );

    assign drop = cv_valid && full && !flush;

    wmf_overflow u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .drop     (drop),
        .clr      (ovf_clr),
        .overflow (overflow)
    );

endmodule

// File: rtl/conv_fifo_wm_chk.sv
module conv_fifo_wm_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              cv_valid,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  wm_level,
    input logic              ovf_clr,
    input logic [CNT_W-1:0]  fill_count,
    input logic              empty,
    input logic              full,
    input logic              irq,
    input logic              overflow
);
    logic [CNT_W-1:0] lvl;
    always_comb begin
        if (wm_level == '0)                 lvl = CNT_W'(1);
        else if (wm_level > CNT_W'(DEPTH))  lvl = CNT_W'(DEPTH);
        else                                lvl = wm_level;
    end

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count <= CNT_W'(DEPTH)) && (empty == (fill_count == '0)) && (full == (fill_count == CNT_W'(DEPTH)))); // R3
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && fill_count >= lvl && !flush) |=> irq); // R4
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && fill_count != '0 && !flush) |=> irq); // R5
    AST_IRQ_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && fill_count == '0) |=> !irq); // R5
    AST_DROP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_valid && full && !flush) |=> overflow); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow); // R7
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !cv_valid && !flush) |=> (rd_data == '0 && empty)); // R8
    AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!empty && !full && cv_valid && rd_en && !flush) |=> $stable(fill_count)); // R9
    AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fill_count == '0 && !irq)); // R10

endmodule

bind conv_fifo_wm conv_fifo_wm_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .cv_valid   (cv_valid),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .wm_level   (wm_level),
    .ovf_clr    (ovf_clr),
    .fill_count (fill_count),
    .empty      (empty),
    .full       (full),
    .irq        (irq),
    .overflow   (overflow)
);

// File: tb/conv_fifo_wm_tb.sv
`timescale 1ns/1ps
module conv_fifo_wm_tb;
    localparam int DW = 16;
    localparam int D  = 8;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0, cv_valid = 1'b0, rd_en = 1'b0, ovf_clr = 1'b0;
    logic [DW-1:0] cv_data = '0;
    logic [CW-1:0] wm_level = '0;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] fill_count;
    logic          empty, full, irq, overflow;

    int n_chk = 0;
    int n_err = 0;

    int m_q [D];
    int m_head = 0, m_tail = 0, m_cnt = 0;
    int m_irq = 0, m_ovf = 0, m_rd = 0;

    always #4 clk = ~clk;

    conv_fifo_wm #(.DATA_W(DW), .DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .cv_valid(cv_valid), .cv_data(cv_data),
        .rd_en(rd_en), .rd_data(rd_data), .wm_level(wm_level), .ovf_clr(ovf_clr),
        .fill_count(fill_count), .empty(empty), .full(full), .irq(irq), .overflow(overflow)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_wm(input int w);
        if (w == 0) return 1;
        if (w > D)  return D;
        return w;
    endfunction

    // One clock: drive at a falling edge, let the rising edge pass, compare at the next falling edge.
    task automatic step(input bit push, input int d, input bit pop, input bit fl, input bit clr);
        int  oc;
        bit  drop;
        int  nirq;
        string tc, ti, to, tr;
        cv_valid = push; cv_data = DW'(d); rd_en = pop; flush = fl; ovf_clr = clr;
        @(negedge clk);
        oc = m_cnt; drop = 0;
        tc = (push && pop && oc > 0 && oc < D) ? "R9" : "R3";
        ti = m_irq ? "R5" : "R4";
        tr = (pop && oc == 0) ? "R8" : "R2";
        if (fl) begin
            m_cnt = 0; m_head = 0; m_tail = 0; m_irq = 0;
            tc = "R10"; ti = "R10";
        end else begin
            nirq = m_irq ? int'(oc != 0) : int'(oc >= eff_wm(int'(wm_level)));
            if (pop) begin
                if (oc > 0) begin m_rd = m_q[m_head]; m_head = (m_head + 1) % D; m_cnt--; end
                else m_rd = 0;
            end
            if (push) begin
                if (oc < D) begin m_q[m_tail] = d; m_tail = (m_tail + 1) % D; m_cnt++; end
                else drop = 1;
            end
            m_irq = nirq;
        end
        to = drop ? "R6" : (fl ? "R10" : "R7");
        if (drop) m_ovf = 1;
        else if (clr) m_ovf = 0;
        chk(tc, "fill_count", int'(fill_count), m_cnt);
        chk(tc, "empty", int'(empty), int'(m_cnt == 0));
        chk(tc, "full", int'(full), int'(m_cnt == D));
        chk(ti, "irq", int'(irq), m_irq);
        chk(to, "overflow", int'(overflow), m_ovf);
        chk(tr, "rd_data", int'(rd_data), m_rd);
        cv_valid = 0; rd_en = 0; flush = 0; ovf_clr = 0;
    endtask

    initial begin
        #(8ns * 200000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "fill_count", int'(fill_count), 0);
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "irq", int'(irq), 0);
        chk("R1", "overflow", int'(overflow), 0);
        chk("R1", "rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep every watermark code through fill, overfill and drain (R4, R5, R6, R8).
        for (int w = 0; w < (1 << CW); w++) begin
            wm_level = CW'(w);
            step(0, 0, 0, 1, 0);
            for (int i = 0; i < D + 2; i++) step(1, w * 256 + i + 1, 0, 0, 0);
            step(0, 0, 0, 0, 0);
            step(0, 0, 0, 0, 0);
            for (int i = 0; i < D + 2; i++) step(0, 0, 1, 0, 0);
            step(0, 0, 0, 0, 0);
            step(0, 0, 0, 0, 1);
        end

        // Watermark met mid-stream while reads and writes interleave (R2, R9).
        wm_level = CW'(3);
        for (int i = 0; i < 4; i++) step(1, 1000 + i, 0, 0, 0);
        for (int i = 0; i < 6; i++) step(1, 2000 + i, 1, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 0);

        // Push and pop together when full: the pop happens, the push is dropped (R6).
        for (int i = 0; i < D; i++) step(1, 3000 + i, 0, 0, 0);
        step(1, 3999, 1, 0, 0);
        // Drop and clear together: the drop wins (R7).
        step(1, 3998, 0, 0, 0);
        step(1, 3997, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        // Flush while irq and overflow are high: overflow kept (R10).
        step(1, 3996, 0, 0, 0);
        step(1, 3995, 1, 1, 0);
        step(0, 0, 0, 0, 0);
        // Push and pop together when empty: empty read gives zero, push taken (R8).
        step(1, 4444, 1, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule